// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor's load/store port and a slower main memory. Every byte address is cut into a tag, a line index, a word-within-block offset and a byte-within-word offset. Each line stores a valid flag, a tag and a block of several data words. A load that finds its line present returns data in the same cycle. Any other access holds the requester in a stall until the memory side has finished its part.

A miss fetches the whole block from memory. The memory returns the block one word per cycle, lowest word first. The tag and valid flag are written when the last word arrives. Every store is written through to memory. If a store misses, the cache first fills the line and then merges the stored word into it. Because of this, a line never mixes words that belong to two different tags. The requester holds its request and fields steady while the stall is high. The request completes in the cycle where the stall is low.

Top module: `dm_wt_cache`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, so the first access to any line is a miss, and with no request the stall and the memory request are low.
- R2: The address fields run from the most significant bit downward as tag, index, word offset and byte offset (defaults: tag [31:8], index [7:4], word offset [3:2], byte offset [1:0]). An access hits only when the indexed line is valid and its stored tag equals the address tag; a differing tag at the same index, even in the top bit, misses.
- R3: A word load (cpu_byte low) that hits returns the addressed word on cpu_rdata in the same cycle with cpu_stall low, and issues no memory request.
- R4: A load miss raises the stall and issues one memory read with mem_we low and a block-aligned mem_addr (offset bits zero). After mem_ready, it takes one word per mem_rvalid, word 0 first, then validates the line and completes the load with the memory data.
- R5: A load with cpu_byte high returns the byte chosen by the byte offset, zero-extended, with offset 0 selecting bits [7:0] (little-endian).
- R6: A store that hits changes only the addressed word of the line; the other words of the block keep their values.
- R7: Every store is written through with one memory write (mem_we high, word-aligned mem_addr, mem_wdata equal to the stored word). The stall stays high until mem_ready. A store always writes the full word, whatever the value of cpu_byte.
- R8: A store that misses first reads the whole block from memory, then merges the stored word and writes it through, so the other words of the line hold memory data for the new tag.
- R9: While mem_req is high and mem_ready is low, mem_req, mem_we and mem_addr hold their values.
- R10: A fill only replaces the line at its own index; lines at other indices stay valid and keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until the stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_byte | input | 1 | Byte load select (loads only) |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the request completes |
| cpu_stall | output | 1 | Requester must hold and wait |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write-through word, 0 = block read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | A fill word is present on mem_rdata |
| mem_rdata | input | DATA_W | Fill word |

## Verification
The bench checks the neighbouring words of a block after a store hit and after a store miss. A design that skipped the block fetch on a write miss would return words belonging to the old tag, and one that wrote the wrong word would corrupt its neighbours. It aliases two addresses to one index, including a pair that differ only in the top tag bit. A design that compared only part of the tag, or ignored the valid flag, would report false hits. It also reads every byte lane, sends a store with the byte flag set, and stretches the memory's accept latency. These tests catch a swapped byte order, a partial-word store, and a request that drifts before it is accepted.

// File: rtl/cache_pkg.sv
// Shared types for the direct-mapped write-through cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cache_pkg;
    // Controller phases: idle lookup, block read request, block fill, write-through.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDREQ = 2'd1,
        ST_FILL  = 2'd2,
        ST_WTHRU = 2'd3
    } cache_state_e;
endpackage

// File: rtl/cache_line_store.sv
// Line storage: per-line valid flag and tag plus a block of data words.
// Reads are combinational at the given index; writes are synchronous.
// Assumes at most one data word and one tag are written per cycle.
module cache_line_store #(
    parameter int DATA_W   = 32,
    parameter int INDEX_W  = 4,
    parameter int BLK_LOG2 = 2,
    parameter int TAG_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INDEX_W-1:0]  idx,
    input  logic [BLK_LOG2-1:0] rd_word,
    output logic                rd_valid,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [BLK_LOG2-1:0] wr_word,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                tag_en,
    input  logic [TAG_W-1:0]    tag_in
);
    localparam int LINES = 1 << INDEX_W;
    localparam int SLOTS = LINES << BLK_LOG2;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [SLOTS];

    // Valid flags: cleared by reset, set when a line's tag is installed.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q      <= '0;
        else if (tag_en) valid_q[idx] <= 1'b1;
    end

    // Tag array write at the end of a fill.
    always_ff @(posedge clk) begin
        if (tag_en) tag_q[idx] <= tag_in;
    end

    // Data array write for fill words and merged stores.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[{idx, wr_word}] <= wr_data;
    end

    // Combinational lookup of the indexed line.
    always_comb begin
        rd_valid = valid_q[idx];
        rd_tag   = tag_q[idx];
        rd_data  = data_q[{idx, rd_word}];
    end

    // R1: the cycle reset is released, no line is valid.
    a_r1_reset_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/cache_byte_select.sv
// Load data formatter: passes the word through or extracts one
// zero-extended byte chosen by the byte offset (offset 0 = bits 7:0).
module cache_byte_select #(
    parameter int DATA_W    = 32,
    parameter int BYTE_LOG2 = 2
) (
    input  logic [DATA_W-1:0]    word_in,
    input  logic [BYTE_LOG2-1:0] byte_off,
    input  logic                 byte_mode,
    output logic [DATA_W-1:0]    data_out
);
    logic [DATA_W-1:0] shifted;

    // Shift the selected byte lane down and mask when a byte is requested.
    always_comb begin
        shifted  = word_in >> {byte_off, 3'b000};
        data_out = byte_mode ? {{(DATA_W-8){1'b0}}, shifted[7:0]} : word_in;
    end
endmodule

// File: rtl/cache_miss_fsm.sv
// Miss and write-through sequencer. Issues a block read on a miss, counts
// fill words, installs the tag on the last word, and issues one memory
// write per store hit. Assumes the requester holds its request while
// stalled and that memory sends fill words only after accepting a read.
module cache_miss_fsm
    import cache_pkg::*;
#(
    parameter int BLK_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic                hit,
    input  logic                mem_ready,
    input  logic                mem_rvalid,
    output logic                mem_req,
    output logic                mem_we,
    output logic                fill_we,
    output logic [BLK_LOG2-1:0] fill_cnt,
    output logic                tag_en,
    output logic                store_we,
    output logic                done
);
    cache_state_e state_q, state_d;
    logic [BLK_LOG2-1:0] cnt_q;

    // Next state and per-cycle controls.
    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        fill_we  = 1'b0;
        tag_en   = 1'b0;
        store_we = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && !hit)        state_d = ST_RDREQ;
                else if (cpu_req && cpu_we) state_d = ST_WTHRU;
                else if (cpu_req)           done    = 1'b1;
            end
            ST_RDREQ: begin
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_FILL;
            end
            ST_FILL: begin
                fill_we = mem_rvalid;
                if (mem_rvalid && (&cnt_q)) begin
                    tag_en  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    store_we = 1'b1;
                    done     = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Fill word counter: cleared on read accept, advanced per fill word.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt_q <= '0;
        else if (state_q == ST_RDREQ && mem_ready) cnt_q <= '0;
        else if (fill_we)                         cnt_q <= cnt_q + 1'b1;
    end

    assign fill_cnt = cnt_q;

    // R9: an unaccepted memory request keeps its kind next cycle.
    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && (mem_we == $past(mem_we))));
endmodule

// File: rtl/dm_wt_cache.sv
// Direct-mapped write-through data cache top. Splits the address into
// tag, index, word offset and byte offset, looks up the line, returns
// hits in the same cycle and stalls for fills and write-throughs.
// Assumes cpu_req and its fields stay constant while cpu_stall is high.
module dm_wt_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int INDEX_W  = 4,
    parameter int BLK_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_byte,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_LOG2 = $clog2(DATA_W / 8);
    localparam int OFF_W     = BLK_LOG2 + BYTE_LOG2;
    localparam int TAG_W     = ADDR_W - INDEX_W - OFF_W;

    logic [TAG_W-1:0]     a_tag;
    logic [INDEX_W-1:0]   a_idx;
    logic [BLK_LOG2-1:0]  a_word;
    logic [BYTE_LOG2-1:0] a_byte;
    logic                 line_valid, hit;
    logic [TAG_W-1:0]     line_tag;
    logic [DATA_W-1:0]    line_word;
    logic                 fill_we, tag_en, store_we, done;
    logic [BLK_LOG2-1:0]  fill_cnt;
    logic                 wr_en;
    logic [BLK_LOG2-1:0]  wr_word;
    logic [DATA_W-1:0]    wr_data;

    // Address field split, most significant first.
    always_comb begin
        a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
        a_idx  = cpu_addr[OFF_W +: INDEX_W];
        a_word = cpu_addr[BYTE_LOG2 +: BLK_LOG2];
        a_byte = cpu_addr[BYTE_LOG2-1:0];
    end

    cache_line_store #(
        .DATA_W(DATA_W), .INDEX_W(INDEX_W), .BLK_LOG2(BLK_LOG2), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .idx(a_idx), .rd_word(a_word),
        .rd_valid(line_valid), .rd_tag(line_tag), .rd_data(line_word),
        .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
        .tag_en(tag_en), .tag_in(a_tag)
    );

    // Hit detection: valid line with matching tag.
    assign hit = line_valid && (line_tag == a_tag);

    cache_miss_fsm #(.BLK_LOG2(BLK_LOG2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .hit(hit), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .mem_we(mem_we), .fill_we(fill_we),
        .fill_cnt(fill_cnt), .tag_en(tag_en), .store_we(store_we), .done(done)
    );

    // Data write source: fill words from memory or the merged store word.
    always_comb begin
        wr_en   = fill_we | store_we;
        wr_word = fill_we ? fill_cnt  : a_word;
        wr_data = fill_we ? mem_rdata : cpu_wdata;
    end

    // Memory address: block aligned for reads, word aligned for writes.
    always_comb begin
        if (mem_we) mem_addr = {cpu_addr[ADDR_W-1:BYTE_LOG2], {BYTE_LOG2{1'b0}}};
        else        mem_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = cpu_wdata;
    end

    cache_byte_select #(.DATA_W(DATA_W), .BYTE_LOG2(BYTE_LOG2)) u_bsel (
        .word_in(line_word), .byte_off(a_byte), .byte_mode(cpu_byte & ~cpu_we),
        .data_out(cpu_rdata)
    );

    // Stall until the sequencer reports completion.
    assign cpu_stall = cpu_req && !done;

    // R3: a load can only complete on a hit.
    a_r3_load_done_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |-> hit);
    // R8: write-through is issued only once the block is in the line.
    a_r8_write_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> hit);
    // R4: the last fill word leaves the requested line valid.
    a_r4_fill_installs_line: assert property (@(posedge clk) disable iff (!rst_n)
        tag_en |=> hit);
    // R9: an unaccepted memory request keeps its address.
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));
endmodule

// File: tb/tb_dm_wt_cache.sv
// Directed bench for dm_wt_cache with a behavioural memory model.
module tb_dm_wt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_unstable = 0;
    int lat = 0, wait_cnt = 0, beat = 0;
    bit streaming = 0, pend_q = 0, finished = 0;
    logic [31:0] base = '0, pend_addr = '0;
    logic [31:0] mm [logic [31:0]];

    always #2 clk = ~clk;   // 250 MHz

    dm_wt_cache dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        return mm.exists(w) ? mm[w] : init_word(w);
    endfunction

    // Memory model: accept after lat cycles, stream 4 words after a read accept.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0; mem_rvalid <= 1'b0;
            streaming = 0; wait_cnt = 0; pend_q = 0;
        end else begin
            if (pend_q && (!mem_req || mem_addr != pend_addr)) n_unstable++;
            pend_q    = mem_req && !mem_ready;
            pend_addr = mem_addr;
            mem_rvalid <= 1'b0;
            if (streaming) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(base + 32'(beat * 4));
                beat++;
                if (beat == 4) streaming = 0;
            end
            if (mem_ready) begin
                mem_ready <= 1'b0;
                wait_cnt = 0;
                if (mem_we) begin mm[mem_addr] = mem_wdata; n_wr++; end
                else begin n_rd++; streaming = 1; beat = 0; base = mem_addr; end
            end else if (mem_req && !streaming) begin
                if (wait_cnt >= lat) mem_ready <= 1'b1;
                else wait_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; returns data and the number of cycles the request was up.
    task automatic access(input logic we, input logic bsel, input logic [31:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_byte = bsel; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        rd = '0;
        while (cyc < 300) begin
            #1;
            cyc++;
            if (!cpu_stall) begin rd = cpu_rdata; break; end
            @(negedge clk);
        end
        @(posedge clk);
        #1 cpu_req = 1'b0; cpu_we = 1'b0; cpu_byte = 1'b0;
    endtask

    localparam logic [31:0] A = 32'h0000_1040;
    localparam logic [31:0] B = 32'h0000_2050;
    localparam logic [31:0] C = 32'h0000_3040;
    localparam logic [31:0] D = 32'h8000_1040;

    task automatic t_reset();
        #1;
        check("R1 stall idle", 32'(cpu_stall), 0);
        check("R1 mem_req idle", 32'(mem_req), 0);
    endtask

    task automatic t_first_load_miss();
        logic [31:0] rd; int cyc; int r0 = n_rd;
        access(0, 0, A + 4, 0, rd, cyc);
        check("R1 R4 miss data", rd, mem_word(A + 4));
        check("R4 one block read", 32'(n_rd - r0), 1);
        check("R1 miss stalls", 32'(cyc > 1), 1);
    endtask

    task automatic t_load_hits();
        logic [31:0] rd; int cyc; int r0 = n_rd;
        for (int k = 0; k < 4; k++) begin
            access(0, 0, A + 32'(4 * k), 0, rd, cyc);
            check("R3 R4 hit word", rd, mem_word(A + 32'(4 * k)));
            check("R3 hit one cycle", 32'(cyc), 1);
        end
        check("R3 no memory read", 32'(n_rd - r0), 0);
    endtask

    task automatic t_byte_loads();
        logic [31:0] rd; int cyc;
        logic [31:0] w = mem_word(A + 4);
        for (int k = 0; k < 4; k++) begin
            access(0, 1, A + 4 + 32'(k), 0, rd, cyc);
            check("R5 byte lane", rd, {24'd0, w[8*k +: 8]});
        end
    endtask

    task automatic t_store_hit();
        logic [31:0] rd; int cyc; int w0 = n_wr; int r0 = n_rd;
        access(1, 0, A + 8, 32'hDEAD_BEEF, rd, cyc);
        check("R7 one write", 32'(n_wr - w0), 1);
        check("R7 memory word", mm[A + 8], 32'hDEAD_BEEF);
        check("R7 stalls for accept", 32'(cyc > 1), 1);
        check("R6 no read on hit", 32'(n_rd - r0), 0);
        access(0, 0, A + 8, 0, rd, cyc);
        check("R6 stored word", rd, 32'hDEAD_BEEF);
        access(0, 0, A + 0, 0, rd, cyc);
        check("R6 neighbour 0", rd, init_word(A + 0));
        access(0, 0, A + 12, 0, rd, cyc);
        check("R6 neighbour 3", rd, init_word(A + 12));
        // Store with cpu_byte set still writes the whole word.
        access(1, 1, A + 13, 32'h1234_5678, rd, cyc);
        check("R7 full word to memory", mm[A + 12], 32'h1234_5678);
        access(0, 0, A + 12, 0, rd, cyc);
        check("R7 full word in line", rd, 32'h1234_5678);
    endtask

    task automatic t_store_miss();
        logic [31:0] rd; int cyc; int w0 = n_wr; int r0 = n_rd;
        access(1, 0, B + 4, 32'hA5A5_5A5A, rd, cyc);
        check("R8 block read first", 32'(n_rd - r0), 1);
        check("R8 write-through", 32'(n_wr - w0), 1);
        check("R8 memory word", mm[B + 4], 32'hA5A5_5A5A);
        for (int k = 0; k < 4; k++) begin
            access(0, 0, B + 32'(4 * k), 0, rd, cyc);
            check("R8 merged line", rd, (k == 1) ? 32'hA5A5_5A5A : init_word(B + 32'(4 * k)));
            check("R8 line hits", 32'(cyc), 1);
        end
        check("R8 no extra read", 32'(n_rd - r0), 1);
    endtask

    task automatic t_conflicts();
        logic [31:0] rd; int cyc; int r0 = n_rd;
        access(0, 0, C + 8, 0, rd, cyc);
        check("R2 same index new tag misses", 32'(n_rd - r0), 1);
        check("R2 conflict data", rd, init_word(C + 8));
        access(0, 0, A + 8, 0, rd, cyc);
        check("R2 evicted line misses", 32'(n_rd - r0), 2);
        check("R2 refetch sees write-through", rd, 32'hDEAD_BEEF);
        access(0, 0, B + 4, 0, rd, cyc);
        check("R10 other line still hits", 32'(cyc), 1);
        check("R10 other line data", rd, 32'hA5A5_5A5A);
        access(0, 0, D, 0, rd, cyc);
        check("R2 top tag bit misses", 32'(n_rd - r0), 3);
        check("R2 top tag bit data", rd, init_word(D));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_first_load_miss();
        t_load_hits();
        t_byte_loads();
        t_store_hit();
        lat = 3;
        t_store_miss();
        t_conflicts();
        check("R9 request held until accept", 32'(n_unstable), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule